// File: doc/BRIEF.md
# Subtractive GCD Engine

This block finds the greatest common divisor of two small unsigned numbers by repeated subtraction. Both operands arrive one after the other on a single shared data bus. Each is taken on a fresh press of an enter input. Once the second operand is in, the engine subtracts the smaller working register from the larger one. It repeats this until the two registers hold the same value, then presents that value as the result and raises a done flag. Another pair can then be entered the same way.

A controller state machine drives the datapath through a small bundle of strobes. The datapath holds the two working registers, `u` and `v`, and a result register. It has no magnitude comparator. One adder, fed through a row of XOR gates that invert one operand, forms the difference. The adder's carry-out and an all-zero test on its sum tell the controller which register to update and when to stop.

Operands of zero are outside the supported range. Their behaviour is left undefined.

Top module: `gcd_engine`

## Requirements
- R1: After a synchronous reset, `done` is 0, `result` is 0, and the block waits for the first operand.
- R2: In the waiting state, a rising edge of `enter` (0 in one clock cycle, 1 in the next) captures `din` as the first operand. The next rising edge captures `din` as the second operand.
- R3: The difference x − y is formed as x + (y XOR all-ones) + 1. A carry-out of 1 means x ≥ y. At each step the larger register is replaced by the larger minus the smaller, so the register that is written never grows.
- R4: When the two registers are equal (zero difference), `result` takes their common value, which is the GCD of the two operands. At the same time `done` goes to 1.
- R5: Holding `enter` high for many cycles advances the capture sequence by exactly one step. A change on `din` while the press is held has no effect.
- R6: Capturing the first operand of a new pair clears `done`. `result` keeps its previous value until the new computation completes.
- R7: Rising edges of `enter` while a computation is running are ignored. They neither change the result nor clear `done`, and they do not count toward the next pair.
- R8: Equal operands finish with `result` equal to that operand and no subtraction.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| din | input | 4 | Operand value, shared by both operands |
| enter | input | 1 | Operand strobe, acted on at its rising edge |
| result | output | 4 | Last computed GCD |
| done | output | 1 | High once a computation has finished, until the next pair starts |

## Verification
Two things can land on the same clock edge: the final compare that finds a zero difference, and a new rising edge of `enter`. The first makes the block idle and ready. The second would capture an operand if the block were already idle. The bench toggles `enter` every other cycle for the whole computation, which puts an edge on or next to the finishing cycle. It then checks that `done` is still high, that `result` equals the expected GCD, and that a following clean pair computes correctly. This shows that no stray press was taken as a first operand.

// File: rtl/gcd_pkg.sv
package gcd_pkg;

  typedef struct packed {
    logic loadU;
    logic loadV;
    logic swapOps;
    logic writeU;
    logic writeV;
    logic latchResult;
  } gcdStrobes_t;

  typedef enum logic [1:0] {
    ST_WAIT_A  = 2'd0,
    ST_WAIT_B  = 2'd1,
    ST_COMPARE = 2'd2,
    ST_SWAP    = 2'd3
  } gcdState_t;

endpackage

// File: rtl/gcd_control.sv
module gcd_control
  import gcd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enter,
  input  logic        sumZero,
  input  logic        carryOut,
  output gcdStrobes_t strobes,
  output logic        done
);

  gcdState_t state;
  gcdState_t nextState;
  logic      enterPrev;
  logic      enterRise;
  logic      doneQ;

  assign enterRise = enter & ~enterPrev;
  assign done      = doneQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_WAIT_A;
      enterPrev <= 1'b0;
      doneQ     <= 1'b0;
    end else begin
      state     <= nextState;
      enterPrev <= enter;
      if (strobes.loadU) begin
        doneQ <= 1'b0;
      end else if (strobes.latchResult) begin
        doneQ <= 1'b1;
      end
    end
  end

  always_comb begin
    strobes   = '0;
    nextState = state;
    case (state)
      ST_WAIT_A: begin
        if (enterRise) begin
          strobes.loadU = 1'b1;
          nextState     = ST_WAIT_B;
        end
      end
      ST_WAIT_B: begin
        if (enterRise) begin
          strobes.loadV = 1'b1;
          nextState     = ST_COMPARE;
        end
      end
      ST_COMPARE: begin
        if (sumZero) begin
          strobes.latchResult = 1'b1;
          nextState           = ST_WAIT_A;
        end else if (carryOut) begin
          strobes.writeU = 1'b1;
        end else begin
          nextState = ST_SWAP;
        end
      end
      ST_SWAP: begin
        strobes.swapOps = 1'b1;
        strobes.writeV  = 1'b1;
        nextState       = ST_COMPARE;
      end
      default: nextState = ST_WAIT_A;
    endcase
  end

  // R5: one press yields a single-cycle edge pulse
  assert_single_edge_R5: assert property (@(posedge clk) disable iff (rst)
    enterRise |=> !enterRise);

  // R6: capturing a new first operand clears done
  assert_done_clear_R6: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT_A && enterRise) |=> !done);

  // R4: done only rises at the end of a compare step
  assert_done_rise_R4: assert property (@(posedge clk) disable iff (rst)
    (!done && !(state == ST_COMPARE && sumZero)) |=> !done);

endmodule

// File: rtl/gcd_datapath.sv
module gcd_datapath
  import gcd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  gcdStrobes_t  strobes,
  output logic [W-1:0] result,
  output logic         carryOut,
  output logic         sumZero
);

  localparam logic [W:0] CarryIn = (W+1)'(1);

  logic [W-1:0] uQ;
  logic [W-1:0] vQ;
  logic [W-1:0] resultQ;
  logic [W-1:0] addA;
  logic [W-1:0] addB;
  logic [W-1:0] invB;
  logic [W-1:0] sum;

  assign addA = strobes.swapOps ? vQ : uQ;
  assign addB = strobes.swapOps ? uQ : vQ;

  for (genvar i = 0; i < W; i++) begin : g_invert
    assign invB[i] = addB[i] ^ 1'b1;
  end

  assign {carryOut, sum} = {1'b0, addA} + {1'b0, invB} + CarryIn;
  assign sumZero = ~|sum;
  assign result  = resultQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      uQ      <= '0;
      vQ      <= '0;
      resultQ <= '0;
    end else begin
      if (strobes.loadU) begin
        uQ <= din;
      end else if (strobes.writeU) begin
        uQ <= sum;
      end
      if (strobes.loadV) begin
        vQ <= din;
      end else if (strobes.writeV) begin
        vQ <= sum;
      end
      if (strobes.latchResult) begin
        resultQ <= uQ;
      end
    end
  end

  // R3: u is only overwritten when it was not smaller than v
  assert_u_no_borrow_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.writeU |-> carryOut);

  // R3: the swapped pass only runs when v exceeds u
  assert_v_no_borrow_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.writeV |-> carryOut);

  // R3: a subtraction step never grows the written register
  assert_u_shrinks_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.writeU |=> (uQ < $past(uQ)));

  // R4: the result is latched only on equal registers
  assert_latch_equal_R4: assert property (@(posedge clk) disable iff (rst)
    strobes.latchResult |-> (sumZero && uQ == vQ));

endmodule

// File: rtl/gcd_engine.sv
module gcd_engine
  import gcd_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  input  logic         enter,
  output logic [W-1:0] result,
  output logic         done
);

  gcdStrobes_t strobes;
  logic        carryOut;
  logic        sumZero;

  gcd_control u_control (
    .clk      (clk),
    .rst      (rst),
    .enter    (enter),
    .sumZero  (sumZero),
    .carryOut (carryOut),
    .strobes  (strobes),
    .done     (done)
  );

  gcd_datapath #(.W(W)) u_datapath (
    .clk      (clk),
    .rst      (rst),
    .din      (din),
    .strobes  (strobes),
    .result   (result),
    .carryOut (carryOut),
    .sumZero  (sumZero)
  );

endmodule

// File: tb/tb_gcd_engine.sv
module tb_gcd_engine;

  localparam int W = 4;
  localparam int NumVec = 12;
  // each entry: {a, b, expected gcd}
  localparam logic [3*W-1:0] Vectors [NumVec] = '{
    {4'd12, 4'd8,  4'd4},  {4'd15, 4'd5,  4'd5},  {4'd9,  4'd6,  4'd3},
    {4'd7,  4'd3,  4'd1},  {4'd1,  4'd15, 4'd1},  {4'd15, 4'd1,  4'd1},
    {4'd14, 4'd10, 4'd2},  {4'd6,  4'd9,  4'd3},  {4'd13, 4'd13, 4'd13},
    {4'd15, 4'd15, 4'd15}, {4'd8,  4'd12, 4'd4},  {4'd10, 4'd4,  4'd2}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] din = '0;
  logic         enter = 1'b0;
  logic [W-1:0] result;
  logic         done;

  int checks = 0;
  int fails = 0;
  logic finished = 1'b0;

  gcd_engine #(.W(W)) dut (
    .clk    (clk),
    .rst    (rst),
    .din    (din),
    .enter  (enter),
    .result (result),
    .done   (done)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic press(input logic [W-1:0] value);
    @(negedge clk);
    din   = value;
    enter = 1'b1;
    @(negedge clk);
    enter = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 200) begin
      @(negedge clk);
      n++;
    end
    check({req, " done within limit"}, int'(done), 1);
  endtask

  task automatic runPair(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [W-1:0] g, input string req);
    press(a);
    press(b);
    waitDone(req);
    check(req, int'(result), int'(g));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", int'(done), 0);
    check("R1 result", int'(result), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 idle", int'(done), 0);

    // R2 R3 R4 R8: table of pairs
    for (int i = 0; i < NumVec; i++) begin
      logic [W-1:0] va;
      logic [W-1:0] vb;
      logic [W-1:0] vg;
      logic [W-1:0] prev;
      {va, vb, vg} = Vectors[i];
      prev = result;
      press(va);
      // R6: done cleared on first capture, result held
      if (i > 0) begin
        check("R6 done cleared", int'(done), 0);
        check("R6 result held", int'(result), int'(prev));
      end
      press(vb);
      check("R6 result held during run", int'(result), int'(prev));
      waitDone("R4");
      check(va == vb ? "R8 equal operands" : "R2 R3 R4 gcd", int'(result), int'(vg));
    end

    // R5: long press with din changing mid-press advances one step
    @(negedge clk);
    din = 4'd12;
    enter = 1'b1;
    repeat (5) @(negedge clk);
    din = 4'd9;
    repeat (3) @(negedge clk);
    enter = 1'b0;
    check("R5 done cleared", int'(done), 0);
    press(4'd8);
    waitDone("R5");
    check("R5 long press", int'(result), 4);

    // R7: presses during computation, including near the finishing edge
    press(4'd1);
    press(4'd15);
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (done) break;
      din   = 4'd2;
      enter = ~enter;
    end
    enter = 1'b0;
    check("R7 done stays set", int'(done), 1);
    check("R7 result", int'(result), 1);
    repeat (2) @(negedge clk);
    check("R7 done after presses", int'(done), 1);
    runPair(4'd6, 4'd4, 4'd2, "R7 next pair");

    // R1: reset mid-computation returns to the initial state
    press(4'd1);
    press(4'd14);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 reset done", int'(done), 0);
    check("R1 reset result", int'(result), 0);
    runPair(4'd9, 4'd12, 4'd3, "R1 after reset");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule